// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer of 9-bit words. Its write port and its read port run on separate clocks. The depth is a parameter (`AW` address bits, so `2**AW` words). The write pointer and the read pointer move between the two domains as Gray codes through two-flop synchronisers. The storage is a plain register array.

A mode input is sampled while master reset is held low, and it fixes the meaning of the two main status flags until the next master reset:

- **Standard mode:** the flags report empty and full. A read enable moves the next word to the output register.
- **Fall-through mode:** the flags report output-ready and input-ready. A small read-side state machine prefetches the oldest word onto the output with no read enable. That output register then acts as one extra word of storage.

In both modes the block also drives three active-low flags: half-full, almost-empty and almost-full. The almost-empty and almost-full thresholds come from an external offset-register block on the `ae_off` and `af_off` inputs.

Three controls move the pointers:

- **Partial reset** clears both pointers but keeps the latched mode.
- **Master reset** clears both pointers and re-latches the mode.
- **Retransmit** (`rt_n` low on a read-clock edge) rewinds the read pointer to location 0, so stored words can be read a second time.

The read-side state machine has three states:

| State | Meaning |
|---|---|
| `ST_STD` | Standard mode. A read pops a word only when storage is not empty. It never leaves this state. |
| `FW_EMPTY` | Fall-through mode with the output register empty. When storage holds a word, that word is fetched and the machine moves to `FW_LOADED`. |
| `FW_LOADED` | Fall-through mode with a word on the output. A read with storage not empty fetches the next word and stays here. A read with storage empty returns to `FW_EMPTY`. |

A retransmit in either fall-through state returns the machine to `FW_EMPTY`. Any reset puts the machine in `ST_STD` or `FW_EMPTY`, depending on the latched mode.

Top module: `dmf_fifo`

## Requirements
- R1: `fwft_sel` is captured on `wclk` edges only while `mrs_n` is low. Changing it during or around a partial reset has no effect on the latched mode: after such a partial reset, standard mode still shows `ff_ir_n` = 1 with the FIFO empty.
- R2: In standard mode, `ef_or_n` is 0 exactly when storage is empty. After master reset, `ef_or_n` = 0, `ff_ir_n` = 1, `hf_n` = 1, `pae_n` = 0 and `paf_n` = 1. A single write raises `ef_or_n` within 6 read-clock cycles.
- R3: In standard mode, `ff_ir_n` goes to 0 once `2**AW` words are held. A write while full is discarded, so the next reads return only the earlier words.
- R4: In standard mode, a read enable with storage not empty loads the oldest word into `dout` on that `rclk` edge, in write order. A read enable while empty leaves `dout` unchanged.
- R5: In fall-through mode, the first word written appears on `dout` with `ef_or_n` = 0 within 6 read-clock cycles, with no read enable. A read enable then replaces it with the next stored word on that edge.
- R6: In fall-through mode, `ff_ir_n` is 0 while storage has space and 1 when storage is full. The prefetched output word is not counted in storage. After master reset, `ef_or_n` = 1 and `ff_ir_n` = 0. A read with nothing stored sets `ef_or_n` to 1.
- R7: `hf_n` is 0 exactly when the stored count exceeds `2**AW`/2.
- R8: `pae_n` is 0 when the stored count is at most `ae_off`. `paf_n` is 0 when the free space (`2**AW` minus the stored count) is at most `af_off`.
- R9: A low pulse on `prs_n` empties the FIFO: afterwards `ef_or_n` = 0 in standard mode.
- R10: `rt_n` low on an `rclk` edge sets the read pointer to location 0. After a partial reset and fewer than `2**AW` writes, the next standard-mode read returns the first word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low; latches the mode |
| prs_n | input | 1 | Partial reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode select, sampled during master reset: 0 = standard, 1 = fall-through |
| wr_en | input | 1 | Write enable, active high |
| din | input | DW | Write data |
| rd_en | input | 1 | Read enable, active high |
| rt_n | input | 1 | Retransmit, active low, sampled on `rclk` |
| ae_off | input | AW+1 | Almost-empty offset from the external offset-register block |
| af_off | input | AW+1 | Almost-full offset from the external offset-register block |
| dout | output | DW | Read data register |
| ef_or_n | output | 1 | Empty flag (standard mode) or output-ready (fall-through mode), active low |
| ff_ir_n | output | 1 | Full flag (standard mode) or input-ready (fall-through mode), active low |
| hf_n | output | 1 | Half-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
A wrong pointer or a wrong synchroniser value shows up at the ports within about four cycles of the write or read that exposed it:

- the empty, full and threshold flags change at the wrong count;
- or a read returns a word out of order.

A wrong read-side state shows in fall-through mode as a missing or stale prefetched word, or as `ef_or_n` stuck in the wrong state, within the fetch latency. A mode latched at the wrong time inverts the polarity of `ff_ir_n` right after the next reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    // Read-side control states.
    typedef enum logic [1:0] {
        ST_STD    = 2'd0,  // standard mode: explicit reads
        FW_EMPTY  = 2'd1,  // fall-through: output register holds nothing
        FW_LOADED = 2'd2   // fall-through: output register holds a word
    } rd_state_t;

endpackage

// File: rtl/dmf_ptr_sync.sv
// Carries a binary pointer into another clock domain as a Gray code
// through two flops, and converts it back to binary at the destination.
module dmf_ptr_sync #(
    parameter int W = 5
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_q <= '0;
        end else begin
            gray_q <= src_bin ^ (src_bin >> 1);
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= gray_q;
            stab_q <= meta_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign dst_bin[i] = ^stab_q[W-1:i];
    end

endmodule

// File: rtl/dmf_store.sv
// Register-array storage: written on the write clock, read combinationally.
module dmf_store #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dmf_wr_side.sv
// Write pointer, plus the flags seen from the write clock:
// full / input-ready, half-full and almost-full.
module dmf_wr_side #(
    parameter int AW = 4
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        mode_fwft,
    input  logic        wr_en,
    input  logic [AW:0] rbin_s,
    input  logic [AW:0] af_off,
    output logic [AW:0] wbin,
    output logic        we,
    output logic        ff_ir_n,
    output logic        hf_n,
    output logic        paf_n
);

    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALF_CNT = FULL_CNT >> 1;

    logic [AW:0] used;
    logic [AW:0] free;
    logic        full;

    assign used = wbin - rbin_s;
    assign free = FULL_CNT - used;
    assign full = (used == FULL_CNT);
    assign we   = wr_en & ~full;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin <= '0;
        end else if (we) begin
            wbin <= wbin + 1'b1;
        end
    end

    always_comb begin
        ff_ir_n = mode_fwft ? full : ~full;
        hf_n    = ~(used > HALF_CNT);
        paf_n   = ~(free <= af_off);
    end

endmodule

// File: rtl/dmf_rd_side.sv
// Read pointer, output register and the read-side state machine
// (standard pops or fall-through prefetch), plus empty/ready and
// almost-empty flags.
module dmf_rd_side
    import dmf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mode_fwft,
    input  logic          rd_en,
    input  logic          rt_n,
    input  logic [AW:0]   wbin_s,
    input  logic [AW:0]   ae_off,
    input  logic [DW-1:0] rdata,
    output logic [AW:0]   rbin,
    output logic [DW-1:0] dout,
    output logic          ef_or_n,
    output logic          pae_n
);

    rd_state_t   state;
    rd_state_t   state_nx;
    logic        pop;
    logic        mem_empty;
    logic [AW:0] avail;

    assign mem_empty = (rbin == wbin_s);
    assign avail     = wbin_s - rbin;

    // Next-state and pop decision.
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            ST_STD: begin
                pop = rd_en & ~mem_empty;
            end
            FW_EMPTY: begin
                if (!mem_empty) begin
                    pop      = 1'b1;
                    state_nx = FW_LOADED;
                end
            end
            FW_LOADED: begin
                if (rd_en) begin
                    if (!mem_empty) begin
                        pop = 1'b1;
                    end else begin
                        state_nx = FW_EMPTY;
                    end
                end
            end
            default: begin
                state_nx = mode_fwft ? FW_EMPTY : ST_STD;
            end
        endcase
        if (!rt_n) begin
            pop      = 1'b0;
            state_nx = (state == ST_STD) ? ST_STD : FW_EMPTY;
        end
    end

    // State register.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= mode_fwft ? FW_EMPTY : ST_STD;
        end else begin
            state <= state_nx;
        end
    end

    // Pointer and data register.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin <= '0;
            dout <= '0;
        end else begin
            if (!rt_n) begin
                rbin <= '0;
            end else if (pop) begin
                rbin <= rbin + 1'b1;
            end
            if (pop) begin
                dout <= rdata;
            end
        end
    end

    // Flags.
    always_comb begin
        if (state == ST_STD) begin
            ef_or_n = ~mem_empty;
        end else begin
            ef_or_n = (state != FW_LOADED);
        end
        pae_n = ~(avail <= ae_off);
    end

endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrs_n,
    input  logic          prs_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    input  logic          rt_n,
    input  logic [AW:0]   ae_off,
    input  logic [AW:0]   af_off,
    output logic [DW-1:0] dout,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);

    logic          rst_n;
    logic          mode_q;
    logic [AW:0]   wbin;
    logic [AW:0]   rbin;
    logic [AW:0]   wbin_s;
    logic [AW:0]   rbin_s;
    logic          we;
    logic [DW-1:0] rdata;

    assign rst_n = mrs_n & prs_n;

    // Mode is captured only while master reset is held.
    always_ff @(posedge wclk) begin
        if (!mrs_n) begin
            mode_q <= fwft_sel;
        end
    end

    dmf_wr_side #(.AW(AW)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .mode_fwft (mode_q),
        .wr_en     (wr_en),
        .rbin_s    (rbin_s),
        .af_off    (af_off),
        .wbin      (wbin),
        .we        (we),
        .ff_ir_n   (ff_ir_n),
        .hf_n      (hf_n),
        .paf_n     (paf_n)
    );

    dmf_store #(.AW(AW), .DW(DW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (wbin[AW-1:0]),
        .wdata (din),
        .raddr (rbin[AW-1:0]),
        .rdata (rdata)
    );

    dmf_rd_side #(.AW(AW), .DW(DW)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .mode_fwft (mode_q),
        .rd_en     (rd_en),
        .rt_n      (rt_n),
        .wbin_s    (wbin_s),
        .ae_off    (ae_off),
        .rdata     (rdata),
        .rbin      (rbin),
        .dout      (dout),
        .ef_or_n   (ef_or_n),
        .pae_n     (pae_n)
    );

    dmf_ptr_sync #(.W(AW + 1)) u_w2r (
        .src_clk (wclk),
        .dst_clk (rclk),
        .rst_n   (rst_n),
        .src_bin (wbin),
        .dst_bin (wbin_s)
    );

    dmf_ptr_sync #(.W(AW + 1)) u_r2w (
        .src_clk (rclk),
        .dst_clk (wclk),
        .rst_n   (rst_n),
        .src_bin (rbin),
        .dst_bin (rbin_s)
    );

endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrs_n,
    input logic          prs_n,
    input logic          mode_q,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt_n,
    input logic [DW-1:0] dout,
    input logic          ef_or_n,
    input logic          ff_ir_n,
    input logic          hf_n,
    input logic          paf_n,
    input logic [AW:0]   af_off,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin
);

    localparam logic [AW:0] HALF_CNT = {2'b01, {(AW - 1){1'b0}}};

    logic any_rst_n;
    assign any_rst_n = mrs_n & prs_n;

    AST_MODE_STABLE: assert property (@(posedge wclk) disable iff (!mrs_n)
        mrs_n |=> $stable(mode_q)); // R1

    AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (!any_rst_n)
        (!mode_q && !ff_ir_n && wr_en) |=> $stable(wbin)); // R3

    AST_EMPTY_READ_HOLDS: assert property (@(posedge rclk) disable iff (!any_rst_n)
        (!mode_q && !ef_or_n && rd_en && rt_n) |=> $stable(dout)); // R4

    AST_PAF_IMPLIES_HF: assert property (@(posedge wclk) disable iff (!any_rst_n)
        ((af_off < HALF_CNT) && !paf_n) |-> !hf_n); // R8

    AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!any_rst_n)
        !rt_n |=> (rbin == '0)); // R10

endmodule

bind dmf_fifo dmf_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .mrs_n   (mrs_n),
    .prs_n   (prs_n),
    .mode_q  (mode_q),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rt_n    (rt_n),
    .dout    (dout),
    .ef_or_n (ef_or_n),
    .ff_ir_n (ff_ir_n),
    .hf_n    (hf_n),
    .paf_n   (paf_n),
    .af_off  (af_off),
    .wbin    (wbin),
    .rbin    (rbin)
);

// File: tb/dmf_fifo_bench.sv
module dmf_fifo_bench;

    localparam int AW = 4;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC = 8;
    // Each entry: bit 9 = 1 write / 0 read, bits 8:0 = data written or expected.
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 9'h101}, {1'b1, 9'h0A2}, {1'b1, 9'h033}, {1'b0, 9'h101},
        {1'b1, 9'h1C4}, {1'b0, 9'h0A2}, {1'b0, 9'h033}, {1'b0, 9'h1C4}
    };

    logic          clk = 1'b0;
    logic          mrs_n = 1'b0;
    logic          prs_n = 1'b1;
    logic          fwft_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic          rd_en = 1'b0;
    logic          rt_n = 1'b1;
    logic [AW:0]   ae_off = 5'd2;
    logic [AW:0]   af_off = 5'd3;
    logic [DW-1:0] dout;
    logic          ef_or_n, ff_ir_n, hf_n, pae_n, paf_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dmf_fifo #(.AW(AW), .DW(DW)) u_dmf_fifo (
        .wclk (clk), .rclk (clk), .mrs_n (mrs_n), .prs_n (prs_n),
        .fwft_sel (fwft_sel), .wr_en (wr_en), .din (din), .rd_en (rd_en),
        .rt_n (rt_n), .ae_off (ae_off), .af_off (af_off), .dout (dout),
        .ef_or_n (ef_or_n), .ff_ir_n (ff_ir_n), .hf_n (hf_n),
        .pae_n (pae_n), .paf_n (paf_n)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        @(negedge clk);
        din = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic master_reset(input logic sel);
        @(negedge clk);
        fwft_sel = sel;
        mrs_n = 1'b0;
        repeat (4) @(negedge clk);
        mrs_n = 1'b1;
        settle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // ---------------- standard mode ----------------
        master_reset(1'b0);
        check("R2 reset ef_n", 9'(ef_or_n), 9'd0);
        check("R2 reset ff_n", 9'(ff_ir_n), 9'd1);
        check("R2 reset hf_n", 9'(hf_n), 9'd1);
        check("R2 reset pae_n", 9'(pae_n), 9'd0);
        check("R2 reset paf_n", 9'(paf_n), 9'd1);

        // Table walk: interleaved writes and reads (R4, R2).
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][9]) begin
                do_write(VEC[i][8:0]);
                settle();
                check("R2 ef_n after write", 9'(ef_or_n), 9'd1);
            end else begin
                do_read();
                check("R4 read order", dout, VEC[i][8:0]);
                settle();
            end
        end
        check("R2 ef_n empty after table", 9'(ef_or_n), 9'd0);
        do_read();
        check("R4 read while empty keeps dout", dout, 9'h1C4);

        // Fill with threshold checks (R7, R8, R3).
        for (int n = 1; n <= DEPTH; n++) begin
            do_write(9'(9'h020 + n - 1));
            settle();
            if (n == 2)  check("R8 pae_n at count 2", 9'(pae_n), 9'd0);
            if (n == 3)  check("R8 pae_n at count 3", 9'(pae_n), 9'd1);
            if (n == 8)  check("R7 hf_n at half", 9'(hf_n), 9'd1);
            if (n == 9)  check("R7 hf_n above half", 9'(hf_n), 9'd0);
            if (n == 12) check("R8 paf_n free 4", 9'(paf_n), 9'd1);
            if (n == 13) check("R8 paf_n free 3", 9'(paf_n), 9'd0);
            if (n == 15) check("R3 ff_n not yet full", 9'(ff_ir_n), 9'd1);
        end
        check("R3 ff_n full", 9'(ff_ir_n), 9'd0);
        do_write(9'h1FF);
        settle();
        check("R3 ff_n stays full", 9'(ff_ir_n), 9'd0);
        for (int i = 0; i < DEPTH; i++) begin
            do_read();
            check("R3 R4 full drain order", dout, 9'(9'h020 + i));
        end
        settle();
        check("R3 empty after drain", 9'(ef_or_n), 9'd0);
        do_read();
        check("R3 dropped word absent", dout, 9'h02F);

        // Partial reset keeps mode (R9, R1).
        do_write(9'h0AA);
        do_write(9'h0BB);
        settle();
        check("R9 ef_n before partial reset", 9'(ef_or_n), 9'd1);
        @(negedge clk);
        fwft_sel = 1'b1;
        prs_n = 1'b0;
        repeat (3) @(negedge clk);
        prs_n = 1'b1;
        settle();
        check("R9 emptied by partial reset", 9'(ef_or_n), 9'd0);
        check("R1 mode kept standard", 9'(ff_ir_n), 9'd1);
        fwft_sel = 1'b0;

        // Retransmit (R10).
        do_write(9'h011);
        do_write(9'h022);
        do_write(9'h033);
        settle();
        do_read();
        do_read();
        check("R10 second word before rewind", dout, 9'h022);
        @(negedge clk);
        rt_n = 1'b0;
        @(negedge clk);
        rt_n = 1'b1;
        settle();
        do_read();
        check("R10 rewind rereads first word", dout, 9'h011);

        // ---------------- fall-through mode ----------------
        master_reset(1'b1);
        check("R6 fwft reset or_n", 9'(ef_or_n), 9'd1);
        check("R6 fwft reset ir_n", 9'(ff_ir_n), 9'd0);
        do_write(9'h055);
        settle();
        check("R5 or_n after first write", 9'(ef_or_n), 9'd0);
        check("R5 word falls through", dout, 9'h055);
        for (int i = 0; i < DEPTH; i++) begin
            do_write(9'(9'h100 + i));
        end
        settle();
        check("R6 ir_n when storage full", 9'(ff_ir_n), 9'd1);
        do_write(9'h1EE);
        settle();
        do_read();
        check("R5 read replaces output", dout, 9'h100);
        settle();
        check("R6 ir_n space again", 9'(ff_ir_n), 9'd0);
        for (int i = 1; i < DEPTH; i++) begin
            do_read();
            check("R5 fwft drain order", dout, 9'(9'h100 + i));
        end
        do_read();
        settle();
        check("R6 or_n after last read", 9'(ef_or_n), 9'd1);
        check("R6 dropped word not shown", dout, 9'h10F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule